// File: doc/BRIEF.md
# DMA Channel Request Sequencer

This block decides when one DMA channel asks for the bus. Software arms the channel with a start bit and chooses, through a mode bit captured at arming, either a self-generated request or a wait for a hardware request. A self-generated request is raised at once and stays raised until the channel reports completion, so transfer units follow each other back to back while the bus stays granted. A hardware request comes either from an interrupt-controller line, which counts while it is low, or from an asynchronous device pin. The pin is synchronised and then taken either by its low level or by its falling edge, as configured.

The block drives a request-pending line and a transfer-unit width toward a fixed-priority bus arbiter. It takes back a grant, a preempt input that stands for a higher-priority channel or bus master taking the bus, and a done input from the address and count logic of the channel. In hardware-request mode each granted unit uses up one request, and the channel then returns to standby.

Top module: `dma_chan_req`

## Requirements
- R1: After reset, req_o, xfer_o, wait_o and done_o are 0 and unit_bytes_o is 1.
- R2: In internal mode (ext_mode_i = 0), raising start_i while the channel is idle sets req_o on the next clock edge.
- R3: In internal mode, while grant_i stays high with no preempt_i and no done_i, xfer_o and req_o stay high on every cycle.
- R4: When a transfer is in progress, preempt_i high or grant_i low makes xfer_o fall on the next edge while req_o stays high. The transfer resumes on the edge that sees grant_i high and preempt_i low.
- R5: In external mode (ext_mode_i = 1), raising start_i puts the channel in standby (wait_o = 1, req_o = 0). It stays there until a hardware request arrives.
- R6: With src_pin_i = 0 captured, a low level on irq_req_n_i sampled in standby sets req_o on that edge.
- R7: With src_pin_i = 1 and edge_mode_i = 0 captured, a low on dev_req_n_i sets req_o on the third clock edge after the pin falls. Two of those edges are the synchroniser stages.
- R8: In level mode a pin held low raises a new request after each granted unit. In falling-edge mode (edge_mode_i = 1) one falling edge gives exactly one request, a held-low pin gives no more, and a later new falling edge gives another.
- R9: In external mode one granted unit (one cycle with xfer_o = 1) returns the channel to standby, provided done_i is low.
- R10: done_i high while a transfer is in progress clears req_o on the next edge and sets done_o. done_o then holds until start_i is cleared.
- R11: start_i low in any state returns the channel to idle on the next edge: req_o, xfer_o, wait_o and done_o all go to 0.
- R12: size_i is captured only when the channel is armed from idle. The code maps 00 to 1 byte, 01 to 2 bytes, and 10 or 11 to 4 bytes on unit_bytes_o. Changes to size_i while the channel is armed have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Arms the channel; low forces idle |
| ext_mode_i | input | 1 | 0 = internal request, 1 = external request (captured at arm) |
| src_pin_i | input | 1 | External source: 0 = interrupt line, 1 = device pin (captured) |
| edge_mode_i | input | 1 | Device pin: 0 = low level, 1 = falling edge (captured) |
| size_i | input | 2 | Transfer unit code (captured) |
| irq_req_n_i | input | 1 | Interrupt-controller request, active low, synchronous |
| dev_req_n_i | input | 1 | Device request pin, active low, asynchronous |
| grant_i | input | 1 | Bus granted to this channel |
| preempt_i | input | 1 | Bus taken by a higher-priority channel or master |
| done_i | input | 1 | Channel operation complete |
| req_o | output | 1 | Request pending toward the arbiter |
| xfer_o | output | 1 | A unit is being moved this cycle |
| wait_o | output | 1 | Standing by for an external request |
| done_o | output | 1 | Channel finished, waiting for start to clear |
| unit_bytes_o | output | 3 | Bytes per transfer unit (1, 2 or 4) |

## Verification
The hardest situation to reach from the ports is falling-edge mode with the device pin held low. There the synchronised level still reads active after the first unit has been served, and only the latched edge tells the mode apart from level mode. The stimulus runs the same held-low pin through level mode and then through edge mode, and expects a second request only in level mode. It then releases the pin long enough to clear the synchroniser, drives a fresh falling edge, and expects a new request on the third edge. The bench gets the cycle of each expected change by counting the two synchroniser flops and the state register.

// File: rtl/dma_req_pkg.sv
`timescale 1ns/1ps
package dma_req_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_STBY = 3'd1,
    ST_REQ  = 3'd2,
    ST_XFER = 3'd3,
    ST_DONE = 3'd4
  } chan_state_e;

  localparam int SIZE_W = 2;
  localparam int UNIT_W = 3;

  function automatic logic [UNIT_W-1:0] size_to_bytes(input logic [SIZE_W-1:0] code);
    logic [UNIT_W-1:0] b;
    case (code)
      2'b00:   b = UNIT_W'(1);
      2'b01:   b = UNIT_W'(2);
      default: b = UNIT_W'(4);
    endcase
    return b;
  endfunction

endpackage

// File: rtl/dma_pin_cond.sv
`timescale 1ns/1ps
module dma_pin_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n_i,
  input  logic edge_mode_i,
  input  logic arm_i,
  input  logic clr_i,
  output logic hit_o
);
  localparam int HIST_W = SYNC_STAGES + 1;

  logic [HIST_W-1:0] shift_q;
  logic              edge_q;
  logic              edge_d;
  logic              pin_sync;
  logic              pin_prev;
  logic              fall;

  // Synchroniser stages plus one history flop for edge detection.
  genvar g;
  generate
    for (g = 0; g < HIST_W; g++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          shift_q[g] <= 1'b1;
        end else begin
          if (g == 0) shift_q[g] <= pin_n_i;
          else        shift_q[g] <= shift_q[(g == 0) ? 0 : g-1];
        end
      end
    end
  endgenerate

  assign pin_sync = shift_q[SYNC_STAGES-1];
  assign pin_prev = shift_q[SYNC_STAGES];
  assign fall     = pin_prev & ~pin_sync;

  always_comb begin
    edge_d = edge_q;
    if (!arm_i) begin
      edge_d = 1'b0;
    end else begin
      edge_d = (edge_mode_i & fall) | (edge_q & ~clr_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) edge_q <= 1'b0;
    else        edge_q <= edge_d;
  end

  assign hit_o = edge_mode_i ? (fall | edge_q) : ~pin_sync;

endmodule

// File: rtl/dma_cfg_hold.sv
`timescale 1ns/1ps
module dma_cfg_hold
  import dma_req_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic              ext_i,
  input  logic              src_pin_i,
  input  logic              edge_i,
  output logic              ext_q_o,
  output logic              src_pin_q_o,
  output logic              edge_q_o,
  output logic [UNIT_W-1:0] unit_bytes_o
);
  logic [SIZE_W-1:0] size_q;
  logic [SIZE_W-1:0] size_d;
  logic              ext_d;
  logic              src_d;
  logic              edge_d;

  always_comb begin
    size_d = size_q;
    ext_d  = ext_q_o;
    src_d  = src_pin_q_o;
    edge_d = edge_q_o;
    if (capture_i) begin
      size_d = size_i;
      ext_d  = ext_i;
      src_d  = src_pin_i;
      edge_d = edge_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q      <= '0;
      ext_q_o     <= 1'b0;
      src_pin_q_o <= 1'b0;
      edge_q_o    <= 1'b0;
    end else begin
      size_q      <= size_d;
      ext_q_o     <= ext_d;
      src_pin_q_o <= src_d;
      edge_q_o    <= edge_d;
    end
  end

  assign unit_bytes_o = size_to_bytes(size_q);

endmodule

// File: rtl/dma_req_fsm.sv
`timescale 1ns/1ps
module dma_req_fsm
  import dma_req_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        ext_live_i,
  input  logic        ext_q_i,
  input  logic        hit_i,
  input  logic        grant_i,
  input  logic        preempt_i,
  input  logic        done_i,
  output chan_state_e state_o,
  output logic        capture_o,
  output logic        take_o
);
  chan_state_e state_q;
  chan_state_e state_d;

  always_comb begin
    state_d = state_q;
    if (!start_i) begin
      state_d = ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE: state_d = ext_live_i ? ST_STBY : ST_REQ;
        ST_STBY: if (hit_i) state_d = ST_REQ;
        ST_REQ:  if (grant_i && !preempt_i) state_d = ST_XFER;
        ST_XFER: begin
          if (done_i)                      state_d = ST_DONE;
          else if (preempt_i || !grant_i)  state_d = ST_REQ;
          else if (ext_q_i)                state_d = ST_STBY;
        end
        ST_DONE: state_d = ST_DONE;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state_o   = state_q;
  assign capture_o = (state_q == ST_IDLE) && start_i;
  assign take_o    = (state_q == ST_REQ) && start_i && grant_i && !preempt_i;

endmodule

// File: rtl/dma_chan_req.sv
`timescale 1ns/1ps
module dma_chan_req
  import dma_req_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              ext_mode_i,
  input  logic              src_pin_i,
  input  logic              edge_mode_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic              irq_req_n_i,
  input  logic              dev_req_n_i,
  input  logic              grant_i,
  input  logic              preempt_i,
  input  logic              done_i,
  output logic              req_o,
  output logic              xfer_o,
  output logic              wait_o,
  output logic              done_o,
  output logic [UNIT_W-1:0] unit_bytes_o
);
  chan_state_e state;
  logic        capture;
  logic        take;
  logic        mode_q;
  logic        src_q;
  logic        edge_cfg_q;
  logic        pin_hit;
  logic        ext_hit;
  logic        armed;

  assign armed   = (state != ST_IDLE);
  assign ext_hit = src_q ? pin_hit : ~irq_req_n_i;

  dma_cfg_hold u_cfg (
    .clk          (clk),
    .rst_n        (rst_n),
    .capture_i    (capture),
    .size_i       (size_i),
    .ext_i        (ext_mode_i),
    .src_pin_i    (src_pin_i),
    .edge_i       (edge_mode_i),
    .ext_q_o      (mode_q),
    .src_pin_q_o  (src_q),
    .edge_q_o     (edge_cfg_q),
    .unit_bytes_o (unit_bytes_o)
  );

  dma_pin_cond #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin_n_i     (dev_req_n_i),
    .edge_mode_i (edge_cfg_q),
    .arm_i       (armed),
    .clr_i       (take),
    .hit_o       (pin_hit)
  );

  dma_req_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .ext_live_i (ext_mode_i),
    .ext_q_i    (mode_q),
    .hit_i      (ext_hit),
    .grant_i    (grant_i),
    .preempt_i  (preempt_i),
    .done_i     (done_i),
    .state_o    (state),
    .capture_o  (capture),
    .take_o     (take)
  );

  assign req_o  = (state == ST_REQ) || (state == ST_XFER);
  assign xfer_o = (state == ST_XFER);
  assign wait_o = (state == ST_STBY);
  assign done_o = (state == ST_DONE);

endmodule

// File: rtl/dma_chan_req_chk.sv
`timescale 1ns/1ps
module dma_chan_req_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       ext_mode_i,
  input logic       grant_i,
  input logic       preempt_i,
  input logic       done_i,
  input logic       req_o,
  input logic       xfer_o,
  input logic       wait_o,
  input logic       done_o,
  input logic [2:0] unit_bytes_o,
  input logic       mode_q
);
  logic idle;
  assign idle = !(req_o || wait_o || done_o);

  p_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_o, wait_o, done_o}) && (!xfer_o || req_o));

  p_int_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && start_i && !ext_mode_i) |=> req_o);

  p_cont_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_o && start_i && grant_i && !preempt_i && !done_i && !mode_q) |=> xfer_o);

  p_preempt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_o && start_i && !done_i && preempt_i) |=> (req_o && !xfer_o));

  p_ext_arm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && start_i && ext_mode_i) |=> (wait_o && !req_o));

  p_ext_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_o && start_i && grant_i && !preempt_i && !done_i && mode_q) |=> wait_o);

  p_done_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_o && start_i && done_i) |=> (!req_o && done_o));

  p_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> (!req_o && !xfer_o && !wait_o && !done_o));

  p_size_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o || wait_o || done_o) |=> $stable(unit_bytes_o));

endmodule

bind dma_chan_req dma_chan_req_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .ext_mode_i   (ext_mode_i),
  .grant_i      (grant_i),
  .preempt_i    (preempt_i),
  .done_i       (done_i),
  .req_o        (req_o),
  .xfer_o       (xfer_o),
  .wait_o       (wait_o),
  .done_o       (done_o),
  .unit_bytes_o (unit_bytes_o),
  .mode_q       (mode_q)
);

// File: tb/dma_chan_req_test.sv
`timescale 1ns/1ps
module dma_chan_req_test;

  logic       clk;
  logic       rst_n;
  logic       start_i, ext_mode_i, src_pin_i, edge_mode_i;
  logic [1:0] size_i;
  logic       irq_req_n_i, dev_req_n_i, grant_i, preempt_i, done_i;
  logic       req_o, xfer_o, wait_o, done_o;
  logic [2:0] unit_bytes_o;

  typedef struct {
    logic       r;
    logic       x;
    logic       w;
    logic       d;
    logic [2:0] b;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_cmp;
  int   n_bad;
  int   wd_cnt;
  bit   finished;

  dma_chan_req uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ext_mode_i(ext_mode_i),
    .src_pin_i(src_pin_i), .edge_mode_i(edge_mode_i), .size_i(size_i),
    .irq_req_n_i(irq_req_n_i), .dev_req_n_i(dev_req_n_i), .grant_i(grant_i),
    .preempt_i(preempt_i), .done_i(done_i), .req_o(req_o), .xfer_o(xfer_o),
    .wait_o(wait_o), .done_o(done_o), .unit_bytes_o(unit_bytes_o)
  );

  initial begin
    clk = 1'b0;
    forever #2 clk = ~clk;
  end

  // Driver: push the outputs expected after the coming rising edge, then advance.
  task automatic t(input logic r, input logic x, input logic w, input logic d,
                   input logic [2:0] b, input string tag);
    exp_t e;
    e.r = r; e.x = x; e.w = w; e.d = d; e.b = b; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
  endtask

  // Monitor: sample 1 ns after each rising edge and compare.
  always begin
    @(posedge clk);
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_cmp++;
      if ({req_o, xfer_o, wait_o, done_o, unit_bytes_o} !== {e.r, e.x, e.w, e.d, e.b}) begin
        n_bad++;
        $display("FAIL %s: actual req=%b xfer=%b wait=%b done=%b bytes=%0d expected req=%b xfer=%b wait=%b done=%b bytes=%0d",
                 e.tag, req_o, xfer_o, wait_o, done_o, unit_bytes_o,
                 e.r, e.x, e.w, e.d, e.b);
      end
    end
  end

  always @(posedge clk) begin
    wd_cnt++;
    if (wd_cnt > 5000 && !finished) begin
      finished = 1'b1;
      n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    n_cmp = 0; n_bad = 0; wd_cnt = 0; finished = 1'b0;
    rst_n = 1'b0; start_i = 1'b0; ext_mode_i = 1'b0; src_pin_i = 1'b0;
    edge_mode_i = 1'b0; size_i = 2'b00; irq_req_n_i = 1'b1; dev_req_n_i = 1'b1;
    grant_i = 1'b0; preempt_i = 1'b0; done_i = 1'b0;
    @(negedge clk);
    // R1 reset state
    t(0,0,0,0,3'd1,"R1");
    t(0,0,0,0,3'd1,"R1");
    rst_n = 1'b1;
    t(0,0,0,0,3'd1,"R1");

    // Internal mode
    size_i = 2'b10; start_i = 1'b1;
    t(1,0,0,0,3'd4,"R2");
    size_i = 2'b00;
    t(1,0,0,0,3'd4,"R12");
    grant_i = 1'b1;
    t(1,1,0,0,3'd4,"R3");
    t(1,1,0,0,3'd4,"R3");
    t(1,1,0,0,3'd4,"R3");
    preempt_i = 1'b1;
    t(1,0,0,0,3'd4,"R4");
    t(1,0,0,0,3'd4,"R4");
    preempt_i = 1'b0;
    t(1,1,0,0,3'd4,"R4");
    grant_i = 1'b0;
    t(1,0,0,0,3'd4,"R4");
    grant_i = 1'b1;
    t(1,1,0,0,3'd4,"R4");
    done_i = 1'b1;
    t(0,0,0,1,3'd4,"R10");
    done_i = 1'b0; grant_i = 1'b0;
    t(0,0,0,1,3'd4,"R10");
    start_i = 1'b0;
    t(0,0,0,0,3'd4,"R11");

    // External mode, interrupt line
    ext_mode_i = 1'b1; src_pin_i = 1'b0; size_i = 2'b01; start_i = 1'b1;
    t(0,0,1,0,3'd2,"R5");
    t(0,0,1,0,3'd2,"R5");
    irq_req_n_i = 1'b0;
    t(1,0,0,0,3'd2,"R6");
    irq_req_n_i = 1'b1; grant_i = 1'b1;
    t(1,1,0,0,3'd2,"R9");
    t(0,0,1,0,3'd2,"R9");
    grant_i = 1'b0;
    t(0,0,1,0,3'd2,"R9");
    start_i = 1'b0;
    t(0,0,0,0,3'd2,"R11");

    // External mode, device pin, level detection
    src_pin_i = 1'b1; edge_mode_i = 1'b0; size_i = 2'b11; start_i = 1'b1;
    t(0,0,1,0,3'd4,"R12");
    dev_req_n_i = 1'b0;
    t(0,0,1,0,3'd4,"R7");
    t(0,0,1,0,3'd4,"R7");
    t(1,0,0,0,3'd4,"R7");
    grant_i = 1'b1;
    t(1,1,0,0,3'd4,"R9");
    t(0,0,1,0,3'd4,"R9");
    t(1,0,0,0,3'd4,"R8");
    t(1,1,0,0,3'd4,"R8");
    start_i = 1'b0; grant_i = 1'b0; dev_req_n_i = 1'b1;
    t(0,0,0,0,3'd4,"R11");
    t(0,0,0,0,3'd4,"R11");
    t(0,0,0,0,3'd4,"R11");
    t(0,0,0,0,3'd4,"R11");

    // External mode, device pin, falling-edge detection
    edge_mode_i = 1'b1; start_i = 1'b1;
    t(0,0,1,0,3'd4,"R5");
    dev_req_n_i = 1'b0;
    t(0,0,1,0,3'd4,"R8");
    t(0,0,1,0,3'd4,"R8");
    t(1,0,0,0,3'd4,"R8");
    grant_i = 1'b1;
    t(1,1,0,0,3'd4,"R8");
    t(0,0,1,0,3'd4,"R8");
    t(0,0,1,0,3'd4,"R8");
    grant_i = 1'b0;
    t(0,0,1,0,3'd4,"R8");
    dev_req_n_i = 1'b1;
    t(0,0,1,0,3'd4,"R8");
    t(0,0,1,0,3'd4,"R8");
    t(0,0,1,0,3'd4,"R8");
    dev_req_n_i = 1'b0;
    t(0,0,1,0,3'd4,"R8");
    t(0,0,1,0,3'd4,"R8");
    t(1,0,0,0,3'd4,"R8");
    start_i = 1'b0;
    t(0,0,0,0,3'd4,"R11");

    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule